// File: doc/BRIEF.md
# Bus Address Decoder with Protection

This block sits on a shared system bus beside the arbiter. Each cycle it looks at the address, transfer type, protection code, direction and size that the active master presents. From these it works out which slave owns the address and whether the access is legal. The outcome is registered, so the one-hot slave selects, the abort flag and the ownership of the wait line all appear one clock after the address phase that produced them.

Each slave region is described by a base, a mask and three permission bits: write allowed, user allowed and fetch allowed. All of these are parameters. The default map has three regions:

- a read-only ROM at 0x0000_0000 (64 KiB);
- a RAM at 0x2000_0000 (64 KiB) that accepts every kind of access;
- a privileged-only, no-execute region at 0x4000_0000 (4 KiB).

When no slave is selected, the decoder owns the wait line and answers at once with wait low. This covers address-only cycles, aborted accesses and reset.

Top module: `bus_addr_decoder`

## Requirements
- R1: While rst_ni is low and on the first cycle after it, sel_o is all zero, abort_o is low, wait_oe_o is high and wait_o is low.
- R2: An active transfer (trans_i[1]=1: 2'b10 nonsequential, 2'b11 sequential) to a mapped region with no violation sets only that region's bit in sel_o on the following cycle, with abort_o low and wait_oe_o low (slave 0 = ROM, 1 = RAM, 2 = privileged region).
- R3: At most one bit of sel_o is ever high.
- R4: Address-only transfers (trans_i=2'b00) and the reserved code 2'b01 select no slave and never abort, whatever their address.
- R5: An active transfer whose address falls in no region aborts on the following cycle and selects nothing.
- R6: Any write to the ROM region aborts, whether privileged or user.
- R7: A user access (prot_i[1]=1; privileged is 0) to the privileged region aborts, and a privileged access there is granted.
- R8: An instruction fetch (prot_i[0]=1; data is 0) from the privileged region aborts. Fetches from ROM and RAM are granted.
- R9: Sizes are coded 2'b00 byte, 2'b01 half-word and 2'b10 word. A half-word needs addr_i[0]=0 and a word needs addr_i[1:0]=0. A misaligned access, or the reserved size 2'b11, aborts.
- R10: Whenever sel_o is all zero, wait_oe_o is high and wait_o is low, so the decoder completes the cycle itself. Whenever a slave is selected, wait_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Bus address from the active master |
| trans_i | input | 2 | Transfer type: 00 address-only, 01 reserved, 10 nonsequential, 11 sequential |
| prot_i | input | 2 | Bit 1 user(1)/privileged(0), bit 0 fetch(1)/data(0) |
| write_i | input | 1 | 1 write, 0 read |
| size_i | input | 2 | 00 byte, 01 half-word, 10 word, 11 reserved |
| sel_o | output | 3 | One-hot slave selects, registered |
| abort_o | output | 1 | Protection, decode or alignment violation, registered |
| wait_o | output | 1 | Wait value the decoder drives when it owns the line |
| wait_oe_o | output | 1 | Decoder owns the wait line this cycle |

## Verification
The hardest cases are accesses where several abort causes could each be to blame, and the exact edges of each region. Examples are a fetch from the privileged region made with privilege, and a word at the last aligned address before a region ends next to one just past it. The stimulus isolates each cause: it changes one attribute at a time against an access that is otherwise legal. Accesses are applied back to back with no idle cycles, so an abort followed at once by a grant checks that the registered outputs carry nothing over from one cycle to the next.

// File: rtl/bad_pkg.sv
package bad_pkg;
  localparam int unsigned PROT_FETCH_BIT = 0;
  localparam int unsigned PROT_USER_BIT  = 1;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_RSVD = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  // active transfer kinds carry data; idle and reserved do not
  function automatic logic is_active(input logic [1:0] t);
    return t[1];
  endfunction
endpackage

// File: rtl/bad_region_match.sv
module bad_region_match #(
  parameter int unsigned NUM_SLV = 3,
  parameter int unsigned AW = 32,
  parameter logic [NUM_SLV*AW-1:0] BASE = '0,
  parameter logic [NUM_SLV*AW-1:0] MASK = '0
) (
  input  logic [AW-1:0]      addr_i,
  output logic [NUM_SLV-1:0] hit_o
);
  logic [NUM_SLV-1:0] raw;

  for (genvar g = 0; g < NUM_SLV; g++) begin : g_rgn
    localparam logic [AW-1:0] RB = BASE[g*AW +: AW];
    localparam logic [AW-1:0] RM = MASK[g*AW +: AW];
    assign raw[g] = ((addr_i & RM) == (RB & RM));
  end

  // overlapping regions: lowest index wins
  always_comb begin
    hit_o = '0;
    for (int i = NUM_SLV - 1; i >= 0; i--) begin
      if (raw[i]) hit_o = NUM_SLV'(1) << i;
    end
  end
endmodule

// File: rtl/bad_prot_check.sv
module bad_prot_check #(
  parameter int unsigned NUM_SLV = 3,
  parameter logic [NUM_SLV-1:0] WR_OK    = '1,
  parameter logic [NUM_SLV-1:0] USER_OK  = '1,
  parameter logic [NUM_SLV-1:0] FETCH_OK = '1
) (
  input  logic [NUM_SLV-1:0] hit_i,
  input  logic               write_i,
  input  logic [1:0]         prot_i,
  output logic               viol_o
);
  import bad_pkg::*;

  logic [NUM_SLV-1:0] deny;

  always_comb begin
    deny = '0;
    if (write_i)                deny = deny | ~WR_OK;
    if (prot_i[PROT_USER_BIT])  deny = deny | ~USER_OK;
    if (prot_i[PROT_FETCH_BIT]) deny = deny | ~FETCH_OK;
    viol_o = |(hit_i & deny);
  end
endmodule

// File: rtl/bad_align_check.sv
module bad_align_check #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  output logic          misalign_o
);
  import bad_pkg::*;

  always_comb begin
    unique case (size_e'(size_i))
      SZ_BYTE: misalign_o = 1'b0;
      SZ_HALF: misalign_o = addr_i[0];
      SZ_WORD: misalign_o = |addr_i[1:0];
      default: misalign_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder #(
  parameter int unsigned NUM_SLV = 3,
  parameter int unsigned AW = 32,
  parameter logic [NUM_SLV*AW-1:0] REGION_BASE =
    {32'h4000_0000, 32'h2000_0000, 32'h0000_0000},
  parameter logic [NUM_SLV*AW-1:0] REGION_MASK =
    {32'hFFFF_F000, 32'hFFFF_0000, 32'hFFFF_0000},
  parameter logic [NUM_SLV-1:0] WR_OK    = 3'b110,
  parameter logic [NUM_SLV-1:0] USER_OK  = 3'b011,
  parameter logic [NUM_SLV-1:0] FETCH_OK = 3'b011
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      addr_i,
  input  logic [1:0]         trans_i,
  input  logic [1:0]         prot_i,
  input  logic               write_i,
  input  logic [1:0]         size_i,
  output logic [NUM_SLV-1:0] sel_o,
  output logic               abort_o,
  output logic               wait_o,
  output logic               wait_oe_o
);
  import bad_pkg::*;

  logic [NUM_SLV-1:0] hit;
  logic               viol, misalign, active, miss, bad, grant;

  bad_region_match #(
    .NUM_SLV(NUM_SLV), .AW(AW), .BASE(REGION_BASE), .MASK(REGION_MASK)
  ) u_match (
    .addr_i(addr_i),
    .hit_o (hit)
  );

  bad_prot_check #(
    .NUM_SLV(NUM_SLV), .WR_OK(WR_OK), .USER_OK(USER_OK), .FETCH_OK(FETCH_OK)
  ) u_prot (
    .hit_i  (hit),
    .write_i(write_i),
    .prot_i (prot_i),
    .viol_o (viol)
  );

  bad_align_check #(.AW(AW)) u_align (
    .addr_i    (addr_i),
    .size_i    (size_i),
    .misalign_o(misalign)
  );

  assign active = is_active(trans_i);
  assign miss   = ~|hit;
  assign bad    = miss | viol | misalign;
  assign grant  = active & ~bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o     <= '0;
      abort_o   <= 1'b0;
      wait_oe_o <= 1'b1;
    end else begin
      sel_o     <= grant ? hit : '0;
      abort_o   <= active & bad;
      wait_oe_o <= ~grant;
    end
  end

  // owned cycles always finish in one beat
  assign wait_o = 1'b0;

  p_onehot_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  p_grant_clean_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sel_o) |-> (!abort_o && !wait_oe_o));

  p_addr_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trans_i[1] |=> (sel_o == '0 && !abort_o));

  p_unmapped_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trans_i[1] && hit == '0) |=> (abort_o && sel_o == '0));

  // R6, R7 and R8 share the permission path
  p_perm_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trans_i[1] && viol) |=> abort_o);

  p_rsvd_size_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trans_i[1] && size_i == 2'b11) |=> abort_o);

  p_wait_owner_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == '0) |-> wait_oe_o);
endmodule

// File: tb/sim_bus_addr_decoder.sv
module sim_bus_addr_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  trans = 2'b00;
  logic [1:0]  prot = 2'b00;
  logic        wr = 1'b0;
  logic [1:0]  size = 2'b10;
  logic [2:0]  sel;
  logic        abort, wt, woe;

  int checks = 0;
  int fails = 0;
  bit running = 1'b0;

  typedef struct {
    logic [2:0] sel;
    logic       abort;
    logic       woe;
    string      tag;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;

  bus_addr_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .trans_i(trans),
    .prot_i(prot), .write_i(wr), .size_i(size),
    .sel_o(sel), .abort_o(abort), .wait_o(wt), .wait_oe_o(woe)
  );

  // reference model written from the requirements
  function automatic exp_t model(input logic [31:0] a, input logic [1:0] t,
                                 input logic [1:0] p, input logic w,
                                 input logic [1:0] s, input string tag);
    exp_t e;
    int   slv;
    bit   bad;
    e.tag = tag;
    e.sel = 3'b000;
    e.abort = 1'b0;
    e.woe = 1'b1;
    if (!t[1]) return e;
    slv = -1;
    if (a[31:16] == 16'h0000)      slv = 0;
    else if (a[31:16] == 16'h2000) slv = 1;
    else if (a[31:12] == 20'h40000) slv = 2;
    bad = (slv < 0);
    if (s == 2'b11) bad = 1'b1;
    if (s == 2'b01 && a[0]) bad = 1'b1;
    if (s == 2'b10 && a[1:0] != 2'b00) bad = 1'b1;
    if (slv == 0 && w) bad = 1'b1;
    if (slv == 2 && (p[1] || p[0])) bad = 1'b1;
    if (bad) e.abort = 1'b1;
    else begin
      e.sel = 3'b001 << slv;
      e.woe = 1'b0;
    end
    return e;
  endfunction

  task automatic drive(input logic [31:0] a, input logic [1:0] t,
                       input logic [1:0] p, input logic w,
                       input logic [1:0] s, input string tag);
    @(negedge clk);
    addr = a; trans = t; prot = p; wr = w; size = s;
    q.push_back(model(a, t, p, w, s, tag));
  endtask

  always @(posedge clk) begin
    if (running && q.size() > 0) begin
      exp_t e;
      #1;
      e = q.pop_front();
      checks++;
      if (sel !== e.sel || abort !== e.abort || woe !== e.woe || wt !== 1'b0) begin
        fails++;
        $display("FAIL %s: sel=%b abort=%b woe=%b wait=%b, expected sel=%b abort=%b woe=%b wait=0",
                 e.tag, sel, abort, woe, wt, e.sel, e.abort, e.woe);
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state, during reset and on the first cycle after it
    repeat (3) @(negedge clk);
    checks++;
    if (sel !== 3'b000 || abort !== 1'b0 || woe !== 1'b1 || wt !== 1'b0) begin
      fails++;
      $display("FAIL R1: sel=%b abort=%b woe=%b wait=%b, expected 000 0 1 0", sel, abort, woe, wt);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (sel !== 3'b000 || abort !== 1'b0 || woe !== 1'b1) begin
      fails++;
      $display("FAIL R1 post-release: sel=%b abort=%b woe=%b, expected 000 0 1", sel, abort, woe);
    end
    running = 1'b1;

    drive(32'h0000_0100, 2'b10, 2'b00, 1'b0, 2'b10, "R2 rom read");
    drive(32'h0000_0004, 2'b11, 2'b11, 1'b0, 2'b10, "R8 rom user fetch");
    drive(32'h2000_0003, 2'b10, 2'b10, 1'b1, 2'b00, "R2 ram user byte write");
    drive(32'h2000_FFFC, 2'b11, 2'b00, 1'b0, 2'b10, "R2 ram top word");
    drive(32'h2000_0010, 2'b10, 2'b01, 1'b0, 2'b10, "R8 ram fetch");
    drive(32'h4000_0FFC, 2'b10, 2'b00, 1'b1, 2'b10, "R7 priv write");
    drive(32'h4000_0010, 2'b10, 2'b10, 1'b0, 2'b10, "R7 user read priv");
    drive(32'h4000_0020, 2'b10, 2'b01, 1'b0, 2'b10, "R8 priv fetch");
    drive(32'h0000_0040, 2'b10, 2'b00, 1'b1, 2'b10, "R6 rom priv write");
    drive(32'h0000_0044, 2'b11, 2'b10, 1'b1, 2'b00, "R6 rom user write");
    drive(32'h2001_0000, 2'b10, 2'b00, 1'b0, 2'b10, "R5 past ram");
    drive(32'h4000_1000, 2'b10, 2'b00, 1'b0, 2'b10, "R5 past priv");
    drive(32'hFFFF_FFFC, 2'b11, 2'b00, 1'b0, 2'b10, "R5 top");
    drive(32'h0000_0000, 2'b00, 2'b00, 1'b1, 2'b10, "R4 idle on rom");
    drive(32'hFFFF_FFFF, 2'b01, 2'b11, 1'b0, 2'b11, "R4 reserved on unmapped");
    drive(32'h2000_0001, 2'b10, 2'b00, 1'b0, 2'b01, "R9 odd half");
    drive(32'h2000_0002, 2'b10, 2'b00, 1'b0, 2'b10, "R9 half-aligned word");
    drive(32'h2000_0002, 2'b10, 2'b00, 1'b0, 2'b01, "R9 aligned half");
    drive(32'h2000_0000, 2'b10, 2'b00, 1'b0, 2'b11, "R9 reserved size");
    drive(32'h4000_0000, 2'b10, 2'b00, 1'b0, 2'b00, "R10 grant after abort");
    drive(32'h2000_0000, 2'b00, 2'b00, 1'b0, 2'b10, "R10 idle after grant");
    drive(32'h0000_FFFE, 2'b11, 2'b00, 1'b0, 2'b01, "R3 rom last half");
    drive(32'h0000_0000, 2'b00, 2'b00, 1'b0, 2'b10, "R4 tail idle");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule